// File: doc/BRIEF.md
# Single-Digit Decimal/Hex Digit Multiplier

This block multiplies two 4-bit digit operands in one combinational pass. In decimal mode both operands are BCD digits (0 to 9), and the product, which never exceeds 81, comes out as a tens digit and a units digit in BCD. In binary mode the same two nibbles are taken as unsigned hex values, and the two output nibbles together carry their full 8-bit binary product. One instance can therefore serve as the digit cell of a decimal multiplier array or of a binary one.

Inside, each set bit of the second operand gates in one shifted copy of the first operand (its x1, x2, x4 and x8 multiples). These copies are formed by wiring and selected through AND/mux logic, so no multiple is ever held in a register. The copies are summed into one binary product. For decimal output the low seven bits of that product go through a shift-and-correct binary-to-BCD converter. This is enough because a product of two valid digits fits in seven bits. The block holds no state and has no clock.

Top module: `bcd_digit_mul`

## Requirements
- R1: With `dec_mode` = 0, `{res_hi, res_lo}` equals the unsigned 8-bit product `opnd_a * opnd_b` for every one of the 256 operand pairs. `res_hi` carries product bits 7:4.
- R2: With `dec_mode` = 1 and both operands in 0..9, `res_lo` equals the product modulo 10.
- R3: With `dec_mode` = 1 and both operands in 0..9, `res_hi` equals the product divided by 10 and rounded down.
- R4: With `dec_mode` = 1 and valid operands, both output digits are legal BCD digits (0..9), and 9 x 9 gives tens 8 and units 1.
- R5: A zero on either operand gives 0 on both outputs in both modes.
- R6: With `dec_mode` = 1 and either operand above 9, both `res_hi` and `res_lo` read 4'hF. No product of valid digits produces this code.
- R7: The outputs depend only on the present inputs. Changing `dec_mode` with the operands held switches the output form at once, and applying the same inputs again gives the same result whatever came before.
- R8: In binary mode, operand codes 10 to 15 are multiplied as their unsigned values. For example, 15 x 15 gives 8'hE1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_mode | input | 1 | 1 selects a two-digit BCD product, 0 selects an 8-bit binary product |
| opnd_a | input | 4 | Multiplicand digit or nibble |
| opnd_b | input | 4 | Multiplier digit or nibble |
| res_hi | output | 4 | Tens digit (decimal mode) or product bits 7:4 (binary mode) |
| res_lo | output | 4 | Units digit (decimal mode) or product bits 3:0 (binary mode) |

## Verification
The block has no registers, so a fault shows at the ports in the same evaluation as the stimulus that exposes it. A wrongly gated multiple corrupts only those pairs in which the matching bit of `opnd_b` is set, so every operand pair is swept in both modes. A faulty correction step in the BCD converter shows as a units digit above 9 or a wrong tens digit on particular products, and the exhaustive decimal sweep covers all of them. The invalid-code override and mode switching are checked directly against the operands held steady.

// File: rtl/bcdm_pkg.sv
package bcdm_pkg;
  localparam int DIG_W   = 4;
  localparam int PROD_W  = 2 * DIG_W;
  localparam int DEC_MAX = 9;
  localparam int DEC_TOP = DEC_MAX * DEC_MAX;
  localparam int DEC_BW  = $clog2(DEC_TOP + 1);
  localparam int DEC_DIG = 2;

  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [PROD_W-1:0] prod_t;

  typedef enum logic {
    OUT_BIN = 1'b0,
    OUT_DEC = 1'b1
  } out_mode_e;

  localparam digit_t DIG_BAD = {DIG_W{1'b1}};
endpackage

// File: rtl/bcdm_multiple_sel.sv
module bcdm_multiple_sel #(
  parameter int W = 4
) (
  input  logic [W-1:0]          mcand_i,
  input  logic [W-1:0]          mplier_i,
  output logic [W-1:0][2*W-1:0] pp_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] base_w;
  assign base_w = {{W{1'b0}}, mcand_i};

  // power-of-two multiples come from wiring; each is gated by one multiplier bit
  for (genvar k = 0; k < W; k++) begin : g_mult
    logic [PW-1:0] shifted_w;
    assign shifted_w = base_w << k;
    assign pp_o[k]   = mplier_i[k] ? shifted_w : '0;
  end

  always_comb begin
    for (int k = 0; k < W; k++) begin
      if (!mplier_i[k])
        AST_PP_GATED: assert (pp_o[k] == '0) else $error("unselected multiple nonzero"); // R5
    end
  end
endmodule

// File: rtl/bcdm_pp_sum.sv
module bcdm_pp_sum #(
  parameter int W = 4
) (
  input  logic [W-1:0][2*W-1:0] pp_i,
  output logic [2*W-1:0]        sum_o
);
  localparam int PW   = 2 * W;
  localparam int NMAX = ((1 << W) - 1) * ((1 << W) - 1);

  logic [PW:0] acc_c;

  always_comb begin
    acc_c = '0;
    for (int k = 0; k < W; k++) begin
      acc_c = acc_c + {1'b0, pp_i[k]};
    end
  end

  assign sum_o = acc_c[PW-1:0];

  always_comb begin
    AST_NO_OVERFLOW: assert (acc_c <= (PW+1)'(NMAX)) else $error("partial sum overflow"); // R1
  end
endmodule

// File: rtl/bcdm_bin2bcd.sv
module bcdm_bin2bcd #(
  parameter int BIN_W  = 7,
  parameter int DIGITS = 2
) (
  input  logic [BIN_W-1:0]    bin_i,
  output logic [DIGITS*4-1:0] bcd_o
);
  localparam int SH_W = DIGITS * 4 + BIN_W;

  logic [SH_W-1:0] sh_c;

  // shift-and-add-3: each digit at 5 or more gets 3 added before it doubles
  always_comb begin
    sh_c = {{(DIGITS*4){1'b0}}, bin_i};
    for (int i = 0; i < BIN_W; i++) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (sh_c[BIN_W + 4*d +: 4] >= 4'd5)
          sh_c[BIN_W + 4*d +: 4] = sh_c[BIN_W + 4*d +: 4] + 4'd3;
      end
      sh_c = sh_c << 1;
    end
  end

  assign bcd_o = sh_c[BIN_W +: DIGITS*4];

  always_comb begin
    if (int'(bin_i) < 10 ** DIGITS) begin
      for (int d = 0; d < DIGITS; d++) begin
        AST_DIGIT_LEGAL: assert (bcd_o[4*d +: 4] <= 4'd9) else $error("digit above 9"); // R4
      end
    end
  end
endmodule

// File: rtl/bcdm_out_sel.sv
module bcdm_out_sel
  import bcdm_pkg::*;
(
  input  out_mode_e             mode_i,
  input  logic                  ops_ok_i,
  input  prod_t                 bin_prod_i,
  input  logic [DEC_DIG*4-1:0]  bcd_prod_i,
  output digit_t                hi_o,
  output digit_t                lo_o
);
  always_comb begin
    unique case (mode_i)
      OUT_BIN: begin
        hi_o = bin_prod_i[PROD_W-1:DIG_W];
        lo_o = bin_prod_i[DIG_W-1:0];
      end
      OUT_DEC: begin
        if (ops_ok_i) begin
          hi_o = bcd_prod_i[7:4];
          lo_o = bcd_prod_i[3:0];
        end else begin
          hi_o = DIG_BAD;
          lo_o = DIG_BAD;
        end
      end
      default: begin
        hi_o = '0;
        lo_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/bcd_digit_mul.sv
module bcd_digit_mul
  import bcdm_pkg::*;
(
  input  logic       dec_mode,
  input  logic [3:0] opnd_a,
  input  logic [3:0] opnd_b,
  output logic [3:0] res_hi,
  output logic [3:0] res_lo
);
  logic [DIG_W-1:0][PROD_W-1:0] pp_w;
  prod_t                        prod_w;
  logic [DEC_DIG*4-1:0]         bcd_w;
  logic                         ops_ok_w;
  out_mode_e                    mode_w;

  assign mode_w   = dec_mode ? OUT_DEC : OUT_BIN;
  assign ops_ok_w = (opnd_a <= DIG_W'(DEC_MAX)) && (opnd_b <= DIG_W'(DEC_MAX));

  bcdm_multiple_sel #(.W(DIG_W)) u_msel (
    .mcand_i  (opnd_a),
    .mplier_i (opnd_b),
    .pp_o     (pp_w)
  );

  bcdm_pp_sum #(.W(DIG_W)) u_sum (
    .pp_i  (pp_w),
    .sum_o (prod_w)
  );

  // valid digit pairs never exceed DEC_TOP, so only DEC_BW bits need converting
  bcdm_bin2bcd #(.BIN_W(DEC_BW), .DIGITS(DEC_DIG)) u_conv (
    .bin_i (prod_w[DEC_BW-1:0]),
    .bcd_o (bcd_w)
  );

  bcdm_out_sel u_osel (
    .mode_i     (mode_w),
    .ops_ok_i   (ops_ok_w),
    .bin_prod_i (prod_w),
    .bcd_prod_i (bcd_w),
    .hi_o       (res_hi),
    .lo_o       (res_lo)
  );

  always_comb begin
    if (!dec_mode)
      AST_BIN_PRODUCT: assert ({res_hi, res_lo} == 8'(opnd_a * opnd_b)) else $error("binary product"); // R1
    if (dec_mode && ops_ok_w)
      AST_DEC_VALUE: assert (int'(res_hi) * 10 + int'(res_lo) == int'(opnd_a) * int'(opnd_b)) else $error("decimal value"); // R3
    if (dec_mode && ops_ok_w)
      AST_UNITS_LEGAL: assert (res_lo <= 4'd9) else $error("units illegal"); // R2
    if (dec_mode && !ops_ok_w)
      AST_BAD_CODE: assert (res_hi == DIG_BAD && res_lo == DIG_BAD) else $error("invalid override"); // R6
  end
endmodule

// File: tb/test_bcd_digit_mul.sv
module test_bcd_digit_mul;
  logic       clk;
  logic       rst_n;
  logic       dec_mode;
  logic [3:0] opnd_a, opnd_b;
  logic [3:0] res_hi, res_lo;
  int         checks;
  int         errors;
  int         wd_cnt;

  bcd_digit_mul i_bcd_digit_mul (
    .dec_mode (dec_mode),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .res_hi   (res_hi),
    .res_lo   (res_lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_cnt <= 0;
    else begin
      wd_cnt <= wd_cnt + 1;
      if (wd_cnt > 20000) begin
        errors = errors + 1;
        $display("FAIL watchdog act=%0d exp<=20000", wd_cnt);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h (mode=%0b a=%0d b=%0d)", req, act, exp, dec_mode, opnd_a, opnd_b);
    end
  endtask

  task automatic drive(input logic m, input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    dec_mode = m;
    opnd_a   = a;
    opnd_b   = b;
    #2;
  endtask

  function automatic logic [7:0] dec_exp(input int a, input int b);
    int p = a * b;
    return {4'((p / 10)), 4'((p % 10))};
  endfunction

  task automatic t_start_zero();
    chk("R5", {res_hi, res_lo}, 8'h00);
    drive(1'b0, 4'd0, 4'd15); chk("R5", {res_hi, res_lo}, 8'h00);
    drive(1'b1, 4'd7, 4'd0);  chk("R5", {res_hi, res_lo}, 8'h00);
  endtask

  task automatic t_binary_sweep();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        drive(1'b0, 4'(a), 4'(b));
        chk("R1", {res_hi, res_lo}, 8'(a * b));
      end
  endtask

  task automatic t_binary_high_codes();
    drive(1'b0, 4'd15, 4'd15); chk("R8", {res_hi, res_lo}, 8'hE1);
    drive(1'b0, 4'd10, 4'd12); chk("R8", {res_hi, res_lo}, 8'd120);
  endtask

  task automatic t_decimal_sweep();
    for (int a = 0; a < 10; a++)
      for (int b = 0; b < 10; b++) begin
        logic [7:0] e;
        drive(1'b1, 4'(a), 4'(b));
        e = dec_exp(a, b);
        chk("R2", {4'd0, res_lo}, {4'd0, e[3:0]});
        chk("R3", {4'd0, res_hi}, {4'd0, e[7:4]});
      end
  endtask

  task automatic t_decimal_extremes();
    drive(1'b1, 4'd9, 4'd9); chk("R4", {res_hi, res_lo}, 8'h81);
    drive(1'b1, 4'd8, 4'd8); chk("R4", {res_hi, res_lo}, 8'h64);
    drive(1'b1, 4'd5, 4'd9); chk("R4", {res_hi, res_lo}, 8'h45);
  endtask

  task automatic t_invalid_codes();
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        if (a > 9 || b > 9) begin
          drive(1'b1, 4'(a), 4'(b));
          chk("R6", {res_hi, res_lo}, 8'hFF);
        end
  endtask

  task automatic t_mode_toggle();
    drive(1'b1, 4'd7, 4'd6); chk("R7", {res_hi, res_lo}, 8'h42);
    drive(1'b0, 4'd7, 4'd6); chk("R7", {res_hi, res_lo}, 8'h2A);
    drive(1'b1, 4'd7, 4'd6); chk("R7", {res_hi, res_lo}, 8'h42);
    drive(1'b1, 4'd12, 4'd6); chk("R7", {res_hi, res_lo}, 8'hFF);
    drive(1'b1, 4'd7, 4'd6); chk("R7", {res_hi, res_lo}, 8'h42);
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    rst_n    = 1'b0;
    dec_mode = 1'b1;
    opnd_a   = 4'd0;
    opnd_b   = 4'd0;
    #45;
    rst_n = 1'b1;
    t_start_zero();
    t_binary_sweep();
    t_binary_high_codes();
    t_decimal_sweep();
    t_decimal_extremes();
    t_invalid_codes();
    t_mode_toggle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule